// File: doc/BRIEF.md
# Serial ADC Conversion Reader

This block is the master side of a byte-framed SPI exchange with a 12-bit serial analog-to-digital converter. A single request, carrying a channel number and an input-type flag (single-ended or differential), makes it select the converter and clock exactly three bytes each way. It then hands back the 12-bit conversion result and frees the converter.

The outgoing command is padded so that the start marker sits after a run of zeros. With that padding the converter's reply ends right-aligned in the last two received bytes. The top three bits of the middle received byte are undefined and the bit below them is a null bit. The block discards all of these and keeps only the low twelve bits of the 24 sampled bits.

The serial clock can idle low or high, chosen per request. In both cases the outgoing data changes on falling edges and incoming data is sampled on rising edges. Every serial clock edge is an enable strobe in the system clock domain, spaced by a parameterised divider.

Top module: `adc_read_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `busy` is 0, `done` is 0, `sclk` is 0 and `result` is 0.
- R2: Each accepted request produces exactly 24 rising and 24 falling `sclk` edges while `cs_n` is low. No edges occur while `cs_n` is high.
- R3: The 24 bits sampled on `mosi` at rising edges are sent MSB first. Positions 23..19 are 0, position 18 is the start bit (1) and position 17 is `single_ended`. Positions 16, 15 and 14 are `chan[2]`, `chan[1]` and `chan[0]`. Positions 13..0 are 0.
- R4: While `cs_n` is low, `mosi` changes only on falling `sclk` edges. `miso` is captured only on rising `sclk` edges.
- R5: `sclk` rests at the level of `idle_high` latched at the request, both at the `cs_n` falling edge and after the last edge. The data roles of rising and falling edges are the same for both levels.
- R6: `result` equals bits 11..0 of the 24 bits presented on `miso`, in order, at the rising edges. Bits 23..12 (undefined, high-impedance and null bits) have no effect on it.
- R7: The first `sclk` edge comes `DIV_HALF` system cycles after `cs_n` falls, and `cs_n` rises `DIV_HALF` cycles after the last edge. `cs_n` then stays high for at least `GAP_HALVES*DIV_HALF` cycles before the next request can select again.
- R8: `busy` is 1 from the cycle after a request is accepted until the release gap ends. A `start` seen while `busy` is 1 is ignored: it produces no extra frame and no extra `done`.
- R9: `done` is a one-cycle pulse in the same cycle that `cs_n` rises. `result` is registered and holds its value until the next `done`.
- R10: Consecutive `sclk` edges within a frame are exactly `DIV_HALF` system cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a conversion read (taken when not busy) |
| chan | input | 3 | Channel number for the request |
| single_ended | input | 1 | 1 = single-ended input, 0 = differential pair |
| idle_high | input | 1 | 1 = serial clock idles high, 0 = idles low |
| busy | output | 1 | A frame or its release gap is in progress |
| done | output | 1 | One-cycle strobe: `result` has been updated |
| result | output | 12 | Last conversion result |
| cs_n | output | 1 | Converter select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Command data to the converter |
| miso | input | 1 | Reply data from the converter |

## Verification
The bench builds the block with `DIV_HALF=3` and `GAP_HALVES=3`. The odd divider shows that edge spacing, select setup and select hold are exact multiples of an arbitrary half period, not only of a power of two. A three-half-period gap, with `start` held high across frames, makes the minimum deselect time visible as a measured count. The short half period keeps each frame near 160 cycles, so the bench can cover both idle levels, several channel and input-type codes, and replies whose twelve discarded high bits are all ones.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_BYTES  = 3;
    localparam int FRAME_W    = BYTE_W * NUM_BYTES;
    localparam int EDGES      = 2 * FRAME_W;
    localparam int RES_W      = 12;
    localparam int CH_W       = 3;
    localparam int LEAD_ZEROS = 5;

    // position of the start marker inside the outgoing frame (MSB first)
    localparam int START_POS  = FRAME_W - 1 - LEAD_ZEROS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic            single_ended;
        logic [CH_W-1:0] chan;
    } adc_cmd_t;

    // zeros, start marker, input-type flag, channel MSB first, zero fill
    function automatic logic [FRAME_W-1:0] pack_cmd(input adc_cmd_t c);
        logic [FRAME_W-1:0] f;
        f = '0;
        f[START_POS]     = 1'b1;
        f[START_POS - 1] = c.single_ended;
        for (int i = 0; i < CH_W; i++) begin
            f[START_POS - 2 - i] = c.chan[CH_W - 1 - i];
        end
        return f;
    endfunction

    // the reply is right-aligned; everything above it is dropped
    function automatic logic [RES_W-1:0] take_result(input logic [FRAME_W-1:0] rx);
        return rx[RES_W-1:0];
    endfunction

endpackage

// File: rtl/adc_half_timer.sv
module adc_half_timer #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    generate
        if (DIV_HALF > 1) begin : g_spacing
            assert_tick_spacing_R10: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/adc_shift_engine.sv
module adc_shift_engine
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_word,
    input  logic               rise_stb,
    input  logic               fall_stb,
    input  logic               miso,
    output logic               mosi,
    output logic [FRAME_W-1:0] rx_word
);
    logic [FRAME_W-1:0] tx_sr;
    logic [FRAME_W-1:0] rx_sr;
    logic               sampled_any;

    assign mosi    = tx_sr[FRAME_W-1];
    assign rx_word = rx_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr       <= '0;
            rx_sr       <= '0;
            sampled_any <= 1'b0;
        end else if (load) begin
            tx_sr       <= load_word;
            rx_sr       <= '0;
            sampled_any <= 1'b0;
        end else begin
            if (rise_stb) begin
                rx_sr       <= {rx_sr[FRAME_W-2:0], miso};
                sampled_any <= 1'b1;
            end
            // a falling edge ahead of any sample keeps the first bit in place
            if (fall_stb && sampled_any) begin
                tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
            end
        end
    end

    assert_mosi_moves_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(mosi) |-> $past(fall_stb || load));

    assert_rx_moves_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_sr) |-> $past(rise_stb || load));

endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq
    import adc_seq_pkg::*;
#(
    parameter int DIV_HALF   = 4,
    parameter int GAP_HALVES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       chan,
    input  logic             single_ended,
    input  logic             idle_high,
    output logic             busy,
    output logic             done,
    output logic [11:0]      result,
    output logic             cs_n,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso
);
    localparam int ECW = $clog2(EDGES + 1);
    localparam int GCW = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;
    localparam logic [ECW-1:0] LAST_EDGE = ECW'(EDGES - 1);
    localparam logic [GCW-1:0] LAST_GAP  = GCW'(GAP_HALVES - 1);

    seq_state_e         state;
    logic [ECW-1:0]     edge_cnt;
    logic [GCW-1:0]     gap_cnt;
    logic               tick;
    logic               sclk_q;
    logic               cs_q;
    logic               done_q;
    logic [RES_W-1:0]   res_q;
    logic               accept;
    logic               edge_now;
    logic               rise_stb;
    logic               fall_stb;
    logic [FRAME_W-1:0] rx_word;
    adc_cmd_t           req;

    assign req.single_ended = single_ended;
    assign req.chan         = chan;

    assign accept   = (state == ST_IDLE) && start;
    assign edge_now = tick && ((state == ST_SETUP) || (state == ST_SHIFT));
    assign rise_stb = edge_now && !sclk_q;
    assign fall_stb = edge_now &&  sclk_q;

    adc_half_timer #(.DIV_HALF(DIV_HALF)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state != ST_IDLE),
        .tick (tick)
    );

    adc_shift_engine u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_word (pack_cmd(req)),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            edge_cnt <= '0;
            gap_cnt  <= '0;
            sclk_q   <= 1'b0;
            cs_q     <= 1'b1;
            done_q   <= 1'b0;
            res_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    sclk_q <= idle_high;
                    if (start) begin
                        cs_q     <= 1'b0;
                        edge_cnt <= '0;
                        state    <= ST_SETUP;
                    end
                end
                ST_SETUP, ST_SHIFT: begin
                    if (tick) begin
                        sclk_q   <= ~sclk_q;
                        edge_cnt <= edge_cnt + 1'b1;
                        state    <= (edge_cnt == LAST_EDGE) ? ST_HOLD : ST_SHIFT;
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        cs_q    <= 1'b1;
                        done_q  <= 1'b1;
                        res_q   <= take_result(rx_word);
                        gap_cnt <= '0;
                        state   <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_cnt == LAST_GAP) begin
                            state <= ST_IDLE;
                        end else begin
                            gap_cnt <= gap_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state != ST_IDLE);
    assign done   = done_q;
    assign result = res_q;
    assign cs_n   = cs_q;
    assign sclk   = sclk_q;

    assert_done_single_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_at_release_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && $past(!cs_n)));

    assert_busy_while_selected_R8: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy);

    assert_no_edges_deselected_R2: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && busy && $past(busy)) |-> $stable(sclk));

    assert_edge_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        edge_cnt <= ECW'(EDGES));

    assert_result_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

endmodule

// File: tb/tb_adc_read_seq.sv
module tb_adc_read_seq;

    localparam int D = 3;
    localparam int G = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  chan = '0;
    logic        single_ended = 1'b0;
    logic        idle_high = 1'b0;
    logic        miso = 1'b0;
    logic        busy, done, cs_n, sclk, mosi;
    logic [11:0] result;

    always #5 clk = ~clk;

    adc_read_seq #(.DIV_HALF(D), .GAP_HALVES(G)) dut (
        .clk(clk), .rst(rst), .start(start), .chan(chan),
        .single_ended(single_ended), .idle_high(idle_high),
        .busy(busy), .done(done), .result(result),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    int checks = 0;
    int errors = 0;

    // monitor / converter model state
    int          cyc = 0;
    logic [23:0] reply = '0;
    logic [23:0] cmd_cap = '0;
    int          k = 0;
    int          rises = 0, falls = 0;
    int          t_cs_fall = 0, t_cs_rise = 0, t_first = -1, t_last = 0, t_done = 0;
    int          cs_gap = -1;
    int          frames = 0, dones = 0, done_run = 0, done_max = 0;
    int          mosi_bad = 0, edges_off = 0;
    logic        lvl_start = 1'b0, lvl_end = 1'b0;
    logic [11:0] res_at_done = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endfunction

    initial begin : monitor
        logic p_cs, p_sclk, p_mosi, p_done;
        p_cs = 1'b1; p_sclk = 1'b0; p_mosi = 1'b0; p_done = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst) begin
                if (p_cs && !cs_n) begin
                    if (frames > 0) cs_gap = cyc - t_cs_rise;
                    t_cs_fall = cyc; rises = 0; falls = 0; t_first = -1;
                    mosi_bad = 0; cmd_cap = '0; k = 0; lvl_start = sclk;
                    miso = reply[23];
                end else if (!p_cs && !cs_n) begin
                    if (mosi != p_mosi && !(p_sclk && !sclk)) mosi_bad++;
                    if (sclk != p_sclk) begin
                        if (t_first < 0) t_first = cyc;
                        t_last = cyc;
                        if (sclk) begin
                            rises++;
                            cmd_cap = {cmd_cap[22:0], mosi};
                            k++;
                        end else begin
                            falls++;
                            if (k > 0 && k < 24) miso = reply[23 - k];
                        end
                    end
                end else if (cs_n && p_cs && sclk != p_sclk && busy) begin
                    edges_off++;
                end
                if (!p_cs && cs_n) begin
                    t_cs_rise = cyc; frames++; lvl_end = sclk;
                end
                if (done) begin
                    dones++; t_done = cyc; res_at_done = result; done_run++;
                    if (done_run > done_max) done_max = done_run;
                end else begin
                    done_run = 0;
                end
            end
            p_cs = cs_n; p_sclk = sclk; p_mosi = mosi; p_done = done;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
        summary();
        $finish;
    end

    task automatic test_reset();
        @(negedge clk);
        chk(cs_n === 1'b1, "R1 cs_n", cs_n, 1);
        chk(busy === 1'b0, "R1 busy", busy, 0);
        chk(done === 1'b0, "R1 done", done, 0);
        chk(sclk === 1'b0, "R1 sclk", sclk, 0);
        chk(result === 12'h000, "R1 result", result, 0);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic do_read(input logic mode, input logic se, input logic [2:0] ch,
                           input logic [23:0] rep);
        int d0;
        logic [23:0] exp_cmd;
        wait_idle();
        @(negedge clk);
        reply = rep; idle_high = mode; single_ended = se; chan = ch;
        d0 = dones;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R8 busy after accept", busy, 1);
        while (dones == d0 && busy) @(negedge clk);
        wait_idle();
        exp_cmd = {5'b00000, 1'b1, se, ch, 14'b0};
        chk(cmd_cap == exp_cmd, "R3 command bits", cmd_cap, exp_cmd);
        chk(rises == 24, "R2 rising edges", rises, 24);
        chk(falls == 24, "R2 falling edges", falls, 24);
        chk(mosi_bad == 0, "R4 mosi change off falling edge", mosi_bad, 0);
        chk(res_at_done == rep[11:0], "R6 result", res_at_done, rep[11:0]);
        chk(result == rep[11:0], "R9 result held", result, rep[11:0]);
        chk(lvl_start == mode && lvl_end == mode, "R5 idle level",
            {lvl_start, lvl_end}, {mode, mode});
        chk(t_first - t_cs_fall == D, "R7 select setup", t_first - t_cs_fall, D);
        chk(t_cs_rise - t_last == D, "R7 select hold", t_cs_rise - t_last, D);
        chk(t_last - t_first == 47 * D, "R10 edge spacing", t_last - t_first, 47 * D);
        chk(t_done == t_cs_rise && dones == d0 + 1, "R9 done at release",
            t_done - t_cs_rise, 0);
        chk(done_max == 1, "R9 done width", done_max, 1);
    endtask

    task automatic test_ignore_start();
        int f0, d0;
        logic [11:0] r0;
        wait_idle();
        @(negedge clk);
        reply = 24'hFFF_5A3; idle_high = 1'b0; single_ended = 1'b1; chan = 3'd2;
        f0 = frames; d0 = dones;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (rises < 10) @(negedge clk);
        chan = 3'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0; chan = 3'd2;
        while (busy) @(negedge clk);
        r0 = result;
        repeat (G * D + 6) @(negedge clk);
        chk(frames == f0 + 1, "R8 start while busy frames", frames - f0, 1);
        chk(dones == d0 + 1, "R8 start while busy dones", dones - d0, 1);
        chk(cs_n === 1'b1, "R8 stays deselected", cs_n, 1);
        chk(cmd_cap == {5'b0, 1'b1, 1'b1, 3'd2, 14'b0}, "R8 command unchanged",
            cmd_cap, {5'b0, 1'b1, 1'b1, 3'd2, 14'b0});
        chk(result == r0 && r0 == 12'h5A3, "R9 result stable while idle", result, 12'h5A3);
    endtask

    task automatic test_back_to_back();
        int f0;
        wait_idle();
        @(negedge clk);
        reply = 24'h000_ABC; idle_high = 1'b1; single_ended = 1'b0; chan = 3'd4;
        f0 = frames;
        start = 1'b1;
        while (frames < f0 + 2) @(negedge clk);
        start = 1'b0;
        chk(cs_gap >= G * D, "R7 deselect gap", cs_gap, G * D);
        wait_idle();
        chk(edges_off == 0, "R2 no edges while deselected", edges_off, 0);
        chk(result == 12'hABC, "R6 back to back result", result, 12'hABC);
    endtask

    initial begin : main
        repeat (3) @(posedge clk);
        test_reset();
        @(negedge clk);
        rst = 1'b0;
        do_read(1'b0, 1'b1, 3'd0, 24'hFFF_000);
        do_read(1'b0, 1'b0, 3'd5, 24'hE1F_FFF);
        do_read(1'b1, 1'b1, 3'd3, 24'hFFF_A5C);
        do_read(1'b1, 1'b0, 3'd6, 24'h000_801);
        do_read(1'b0, 1'b1, 3'd7, 24'h123_456);
        test_ignore_start();
        test_back_to_back();
        summary();
        $finish;
    end

endmodule